// File: doc/BRIEF.md
# Per-Lane Flat Memory Access Unit

This unit carries out one lane's flat or global memory operation. It takes an opcode, a choice of address mode, an immediate offset and register indices. It then forms a 64-bit byte address and moves data between a vector register file port and a synchronous byte-addressed memory port. Each memory beat is 1, 2 or 4 bytes wide.

Whole-dword transfers of one to four dwords are supported, as are sub-dword loads with zero or sign extension and byte or halfword stores. Half-register operations are also supported: they load into the low or high 16 bits of a register, or store from its upper half. A fixed set of address windows, given by parameters, filters every beat. A beat that does not fit entirely inside one window never reaches the memory port. Reads of such a beat return zero.

Only one operation is in flight at a time. The unit accepts an operation when it is idle and signals completion with a one-cycle done pulse.

Top module: `flat_lane_mem`

## Requirements
- R1: `op_ready` is high only while idle, and an operation is accepted at a clock edge where `op_valid` and `op_ready` are both high. The address phase takes 1 cycle, plus 1 more in paired-register mode. Each load beat takes 2 cycles (request, then response) and each store beat takes 1. `done` is high for exactly one cycle, at the end of the last of these cycles, and `op_ready` returns in the following cycle. An illegal opcode gives `done` in the cycle right after acceptance.
- R2: When `op_sreg` is not 7'h7F, the address is `op_sbase` plus the zero-extended register `op_areg` plus the sign-extended 13-bit `op_off`, wrapping modulo 2^64.
- R3: When `op_sreg` equals 7'h7F, the address is {reg[`op_areg`+1], reg[`op_areg`]} plus the sign-extended `op_off`, wrapping modulo 2^64.
- R4: Opcodes 4 to 7 load 1 to 4 dwords (count = opcode − 3). Beat k reads 4 bytes at address+4k into register `op_dreg`+k, with register indices wrapping at 256. Read data arrives on `mem_rdata` in the cycle after the request.
- R5: Opcodes 12 to 15 store 1 to 4 dwords (count = opcode − 11). Beat k writes register `op_dreg`+k to address+4k.
- R6: Opcode 0 is an unsigned byte load, 1 a signed byte load, 2 an unsigned halfword load and 3 a signed halfword load. Each fills the full 32-bit destination.
- R7: Opcode 8 stores the low byte and opcode 9 the low halfword of `op_dreg`. `mem_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Data on `mem_wdata`/`mem_rdata` is little-endian, starting at bit 0.
- R8: Half-register loads write only one half of `op_dreg` and keep the other half. Opcodes 16, 17 and 18 target the low half; opcodes 20, 21 and 22 target the high half. They load, in that order, an unsigned byte, a byte sign-extended to 16 bits, and a halfword.
- R9: Opcode 24 stores the low byte and opcode 25 all 16 bits of the upper half of `op_dreg`.
- R10: A beat counts as inside a window only if all of its bytes lie within it. A beat outside every window issues no memory request, so a store beat is dropped and a load beat writes zero (before extension or insertion).
- R11: Any other opcode completes with `err` high together with `done`. It makes no memory request and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation can be taken |
| op_code | input | 5 | Operation code |
| op_sreg | input | 7 | Scalar base selector, 7'h7F selects paired-register mode |
| op_sbase | input | 64 | Scalar base value |
| op_areg | input | RIDX | Address register index |
| op_dreg | input | RIDX | Data register base index (destination or source) |
| op_off | input | 13 | Signed immediate offset |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal opcode, valid with done |
| rf_raddr | output | RIDX | Register file read index |
| rf_rdata | input | 32 | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | RIDX | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 64 | Beat byte address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |

## Verification
In the response cycle of a half-register load, the unit reads the old destination register and writes the merged result into that same register in one cycle. A wide load whose destination range covers its own address registers similarly combines a register read and a later overwrite of it. Both cases are provoked by back-to-back low and high half loads into one register, and by random register indices that often overlap. The result is judged by comparing the whole register file and memory against a bench model after every operation.

// File: rtl/flat_lane_mem.sv
module flat_lane_mem #(
  parameter int RIDX = 8,
  parameter int NWIN = 2,
  parameter logic [NWIN*64-1:0] WIN_BASE = {64'hFFFF_FFFF_FFFF_FF00, 64'h0000_0000_0000_1000},
  parameter logic [NWIN*64-1:0] WIN_SIZE = {64'h100, 64'h100}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [4:0]      op_code,
  input  logic [6:0]      op_sreg,
  input  logic [63:0]     op_sbase,
  input  logic [RIDX-1:0] op_areg,
  input  logic [RIDX-1:0] op_dreg,
  input  logic [12:0]     op_off,
  output logic            done,
  output logic            err,
  output logic [RIDX-1:0] rf_raddr,
  input  logic [31:0]     rf_rdata,
  output logic            rf_we,
  output logic [RIDX-1:0] rf_waddr,
  output logic [31:0]     rf_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [63:0]     mem_addr,
  output logic [1:0]      mem_size,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata
);
  localparam logic [6:0] NULL_BASE = 7'h7F;

  typedef enum logic [2:0] {S_IDLE, S_ALO, S_AHI, S_MEM, S_RSP, S_FIN} st_t;

  function automatic logic legal(input logic [4:0] c);
    return c inside {[5'd0:5'd9], [5'd12:5'd18], [5'd20:5'd22], 5'd24, 5'd25};
  endfunction

  st_t             st;
  logic [4:0]      code_q;
  logic            null_q, err_q, inwin_q;
  logic [63:0]     sbase_q, addr_q;
  logic [RIDX-1:0] areg_q, dreg_q;
  logic [12:0]     off_q;
  logic [31:0]     lo_q;
  logic [1:0]      beat_q;

  logic wide, is_st, d16, hi, sgn, inwin;
  logic [1:0]  sz, last;
  logic [63:0] off64, baddr;
  logic [64:0] bend;
  logic [31:0] rd, src;
  logic [15:0] ld16;

  assign wide  = (code_q[4:2] == 3'b001) || (code_q[4:2] == 3'b011);
  assign is_st = code_q inside {5'd8, 5'd9, [5'd12:5'd15], 5'd24, 5'd25};
  assign d16   = code_q[4] && !code_q[3];
  assign hi    = d16 ? code_q[2] : (code_q[4:3] == 2'b11);
  assign sgn   = !is_st && !wide && code_q[0];
  assign sz    = wide ? 2'd2 : {1'b0, is_st ? code_q[0] : code_q[1]};
  assign last  = wide ? code_q[1:0] : 2'd0;

  assign off64 = {{51{off_q[12]}}, off_q};
  assign baddr = addr_q + {60'd0, beat_q, 2'b00};
  assign bend  = {1'b0, baddr} + (65'd1 << sz);

  always_comb begin
    inwin = 1'b0;
    for (int i = 0; i < NWIN; i++)
      if (baddr >= WIN_BASE[i*64 +: 64] &&
          bend <= {1'b0, WIN_BASE[i*64 +: 64]} + {1'b0, WIN_SIZE[i*64 +: 64]})
        inwin = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; code_q <= '0; null_q <= 1'b0; err_q <= 1'b0; inwin_q <= 1'b0;
      sbase_q <= '0; addr_q <= '0; areg_q <= '0; dreg_q <= '0; off_q <= '0;
      lo_q <= '0; beat_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (op_valid) begin
          code_q  <= op_code;
          null_q  <= (op_sreg == NULL_BASE);
          sbase_q <= op_sbase;
          areg_q  <= op_areg;
          dreg_q  <= op_dreg;
          off_q   <= op_off;
          beat_q  <= '0;
          err_q   <= !legal(op_code);
          st      <= legal(op_code) ? S_ALO : S_FIN;
        end
        S_ALO: if (null_q) begin
          lo_q <= rf_rdata;
          st   <= S_AHI;
        end else begin
          addr_q <= sbase_q + {32'd0, rf_rdata} + off64;
          st     <= S_MEM;
        end
        S_AHI: begin
          addr_q <= {rf_rdata, lo_q} + off64;
          st     <= S_MEM;
        end
        S_MEM: begin
          inwin_q <= inwin;
          if (!is_st) st <= S_RSP;
          else if (beat_q == last) st <= S_FIN;
          else beat_q <= beat_q + 2'd1;
        end
        S_RSP: if (beat_q == last) st <= S_FIN;
               else begin beat_q <= beat_q + 2'd1; st <= S_MEM; end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign op_ready = (st == S_IDLE);
  assign done     = (st == S_FIN);
  assign err      = done && err_q;

  always_comb begin
    case (st)
      S_ALO:   rf_raddr = areg_q;
      S_AHI:   rf_raddr = areg_q + RIDX'(1);
      default: rf_raddr = dreg_q + RIDX'(beat_q);
    endcase
  end

  assign src       = hi ? {16'd0, rf_rdata[31:16]} : rf_rdata;
  assign mem_req   = (st == S_MEM) && inwin;
  assign mem_we    = is_st;
  assign mem_addr  = baddr;
  assign mem_size  = sz;
  assign mem_wdata = (sz == 2'd0) ? {24'd0, src[7:0]} :
                     (sz == 2'd1) ? {16'd0, src[15:0]} : src;

  assign rd   = inwin_q ? mem_rdata : 32'd0;
  assign ld16 = (sz == 2'd1) ? rd[15:0] : {{8{sgn & rd[7]}}, rd[7:0]};

  assign rf_we    = (st == S_RSP);
  assign rf_waddr = dreg_q + RIDX'(beat_q);
  assign rf_wdata = d16 ? (hi ? {ld16, rf_rdata[15:0]} : {rf_rdata[31:16], ld16}) :
                    wide ? rd :
                    (sz == 2'd1) ? {{16{sgn & rd[15]}}, rd[15:0]} :
                    {{24{sgn & rd[7]}}, rd[7:0]};

  a_r1_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> !op_ready);
  a_r1_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> op_ready && !done);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !mem_req && !rf_we);
  a_r11_bad_op_done: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && !legal(op_code) |=> done && err);
  a_r11_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r5_store_no_rf_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !rf_we);
endmodule

// File: tb/tb_flat_lane_mem.sv
module tb_flat_lane_mem;
  localparam logic [63:0] W0 = 64'h0000_0000_0000_1000;
  localparam logic [63:0] W1 = 64'hFFFF_FFFF_FFFF_FF00;
  localparam logic [63:0] WS = 64'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        op_valid = 1'b0, op_ready, done, err;
  logic [4:0]  op_code = '0;
  logic [6:0]  op_sreg = '0;
  logic [63:0] op_sbase = '0;
  logic [7:0]  op_areg = '0, op_dreg = '0;
  logic [12:0] op_off = '0;
  logic [7:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;
  logic        rf_we, mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [1:0]  mem_size;

  flat_lane_mem #(.RIDX(8), .NWIN(2), .WIN_BASE({W1, W0}), .WIN_SIZE({WS, WS})) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .op_sreg(op_sreg), .op_sbase(op_sbase), .op_areg(op_areg), .op_dreg(op_dreg), .op_off(op_off),
    .done(done), .err(err), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [31:0] rf [256];
  logic [7:0]  mem [1024];
  logic [31:0] exp_rf [256];
  logic [7:0]  exp_mem [1024];
  logic [31:0] rdq = '0;
  int nchk = 0, nfail = 0;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = rdq;

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_req) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (i < (1 << mem_size)) mem[mem_addr[9:0] + 10'(i)] <= mem_wdata[8*i +: 8];
      end else begin
        for (int i = 0; i < 4; i++) rdq[8*i +: 8] <= mem[mem_addr[9:0] + 10'(i)];
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic win_ok(input logic [63:0] a, input int nb);
    logic [64:0] e = {1'b0, a} + 65'(nb);
    if (a >= W0 && e <= {1'b0, W0} + {1'b0, WS}) return 1'b1;
    if (a >= W1 && e <= {1'b0, W1} + {1'b0, WS}) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] mread(input logic [63:0] a, input int nb);
    logic [31:0] v = '0;
    if (win_ok(a, nb))
      for (int i = 0; i < nb; i++) v[8*i +: 8] = exp_mem[a[9:0] + 10'(i)];
    return v;
  endfunction

  task automatic mwrite(input logic [63:0] a, input int nb, input logic [31:0] v);
    if (win_ok(a, nb))
      for (int i = 0; i < nb; i++) exp_mem[a[9:0] + 10'(i)] = v[8*i +: 8];
  endtask

  function automatic string tag_of(input logic [4:0] c);
    if (c <= 5'd3) return "R6";
    if (c <= 5'd7) return "R4";
    if (c == 5'd8 || c == 5'd9) return "R7";
    if (c >= 5'd12 && c <= 5'd15) return "R5";
    if (c inside {[5'd16:5'd18], [5'd20:5'd22]}) return "R8";
    if (c == 5'd24 || c == 5'd25) return "R9";
    return "R11";
  endfunction

  task automatic model(input logic [4:0] c, input logic [6:0] sreg, input logic [63:0] sbase,
                       input logic [7:0] ar, input logic [7:0] d, input logic [12:0] off,
                       output logic xerr, output int lat);
    logic [63:0] a, so;
    logic [31:0] v;
    int beats;
    logic ld;
    so = {{51{off[12]}}, off};
    if (sreg != 7'h7F) a = sbase + {32'd0, exp_rf[ar]} + so;
    else a = {exp_rf[8'(ar + 8'd1)], exp_rf[ar]} + so;
    xerr = 1'b0; beats = 1; ld = 1'b1;
    case (c)
      5'd0: begin v = mread(a, 1); exp_rf[d] = {24'd0, v[7:0]}; end
      5'd1: begin v = mread(a, 1); exp_rf[d] = {{24{v[7]}}, v[7:0]}; end
      5'd2: begin v = mread(a, 2); exp_rf[d] = {16'd0, v[15:0]}; end
      5'd3: begin v = mread(a, 2); exp_rf[d] = {{16{v[15]}}, v[15:0]}; end
      5'd4, 5'd5, 5'd6, 5'd7: begin
        beats = int'(c) - 3;
        for (int k = 0; k < beats; k++) exp_rf[8'(d + 8'(k))] = mread(a + 64'(4*k), 4);
      end
      5'd8: begin ld = 1'b0; mwrite(a, 1, exp_rf[d]); end
      5'd9: begin ld = 1'b0; mwrite(a, 2, exp_rf[d]); end
      5'd12, 5'd13, 5'd14, 5'd15: begin
        ld = 1'b0; beats = int'(c) - 11;
        for (int k = 0; k < beats; k++) mwrite(a + 64'(4*k), 4, exp_rf[8'(d + 8'(k))]);
      end
      5'd16: begin v = mread(a, 1); exp_rf[d][15:0] = {8'd0, v[7:0]}; end
      5'd17: begin v = mread(a, 1); exp_rf[d][15:0] = {{8{v[7]}}, v[7:0]}; end
      5'd18: begin v = mread(a, 2); exp_rf[d][15:0] = v[15:0]; end
      5'd20: begin v = mread(a, 1); exp_rf[d][31:16] = {8'd0, v[7:0]}; end
      5'd21: begin v = mread(a, 1); exp_rf[d][31:16] = {{8{v[7]}}, v[7:0]}; end
      5'd22: begin v = mread(a, 2); exp_rf[d][31:16] = v[15:0]; end
      5'd24: begin ld = 1'b0; mwrite(a, 1, {16'd0, exp_rf[d][31:16]}); end
      5'd25: begin ld = 1'b0; mwrite(a, 2, {16'd0, exp_rf[d][31:16]}); end
      default: xerr = 1'b1;
    endcase
    if (xerr) lat = 0;
    else lat = 1 + ((sreg == 7'h7F) ? 1 : 0) + beats * (ld ? 2 : 1);
  endtask

  task automatic run_op(input logic [4:0] c, input logic [6:0] sreg, input logic [63:0] sbase,
                        input logic [7:0] ar, input logic [7:0] d, input logic [12:0] off,
                        input string tag);
    logic xerr, gerr;
    int lat, seen, bad;
    for (int i = 0; i < 256; i++) exp_rf[i] = rf[i];
    for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
    model(c, sreg, sbase, ar, d, off, xerr, lat);
    @(negedge clk);
    op_code = c; op_sreg = sreg; op_sbase = sbase; op_areg = ar; op_dreg = d; op_off = off;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    seen = -1; gerr = 1'b0;
    for (int k = 0; k < 40 && seen < 0; k++) begin
      if (done) begin seen = k; gerr = err; end
      else @(negedge clk);
    end
    chk(seen == lat, "R1", "done latency", 64'(seen), 64'(lat));
    chk(gerr == xerr, tag, "err flag", {63'd0, gerr}, {63'd0, xerr});
    bad = -1;
    for (int i = 0; i < 256; i++) if (bad < 0 && rf[i] !== exp_rf[i]) bad = i;
    if (bad < 0) chk(1'b1, tag, "register file", 0, 0);
    else chk(1'b0, tag, $sformatf("register %0d", bad), {32'd0, rf[bad]}, {32'd0, exp_rf[bad]});
    bad = -1;
    for (int i = 0; i < 1024; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) chk(1'b1, tag, "memory", 0, 0);
    else chk(1'b0, tag, $sformatf("memory byte %0d", bad), {56'd0, mem[bad]}, {56'd0, exp_mem[bad]});
    @(negedge clk);
    chk(!done && op_ready, "R1", "single done pulse then ready", {62'd0, done, op_ready}, 64'd1);
  endtask

  task automatic aim(input logic [63:0] target, input logic nul, input logic [12:0] off,
                     input logic [7:0] ar, output logic [6:0] sreg, output logic [63:0] sbase);
    logic [63:0] so, p;
    logic [31:0] v;
    so = {{51{off[12]}}, off};
    if (nul) begin
      p = target - so;
      rf[ar] = p[31:0]; rf[8'(ar + 8'd1)] = p[63:32];
      sreg = 7'h7F; sbase = {$urandom, $urandom};
    end else begin
      v = $urandom;
      rf[ar] = v;
      sbase = target - so - {32'd0, v};
      sreg = 7'($urandom % 127);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [6:0] sr;
    logic [63:0] sb;
    logic [4:0] legal_codes [22];
    logic [4:0] bad_codes [8];
    void'($urandom(32'd20240611));
    legal_codes = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd12, 5'd13,
                    5'd14, 5'd15, 5'd16, 5'd17, 5'd18, 5'd20, 5'd21, 5'd22, 5'd24, 5'd25};
    bad_codes = '{5'd10, 5'd11, 5'd19, 5'd23, 5'd26, 5'd27, 5'd30, 5'd31};
    for (int i = 0; i < 256; i++) rf[i] = $urandom;
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(op_ready && !done && !mem_req && !rf_we, "R1", "reset state",
        {60'd0, op_ready, done, mem_req, rf_we}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4: wrapping scalar-base sum, negative offset, four-dword load
    aim(W0 + 64'h20, 1'b0, 13'h1FF0, 8'd5, sr, sb);
    run_op(5'd7, sr, sb, 8'd5, 8'd40, 13'h1FF0, "R4");
    // R2: most negative offset
    aim(W0 + 64'h40, 1'b0, 13'h1000, 8'd6, sr, sb);
    run_op(5'd4, sr, sb, 8'd6, 8'd41, 13'h1000, "R2");
    // R3: paired-register mode at top of upper window
    aim(W1 + 64'hF8, 1'b1, 13'h0005, 8'd7, sr, sb);
    run_op(5'd5, sr, sb, 8'd7, 8'd50, 13'h0005, "R3");
    // R5: three-dword store
    aim(W0 + 64'h80, 1'b0, 13'h0010, 8'd8, sr, sb);
    run_op(5'd14, sr, sb, 8'd8, 8'd60, 13'h0010, "R5");
    // R6: byte 0x9C and halfword 0x8001, signed and unsigned
    mem[10'h011] = 8'h9C; mem[10'h012] = 8'h01; mem[10'h013] = 8'h80;
    aim(W0 + 64'h11, 1'b0, 13'h0, 8'd9, sr, sb);  run_op(5'd1, sr, sb, 8'd9, 8'd70, 13'h0, "R6");
    aim(W0 + 64'h11, 1'b1, 13'h3, 8'd9, sr, sb);  run_op(5'd0, sr, sb, 8'd9, 8'd71, 13'h3, "R6");
    aim(W0 + 64'h12, 1'b0, 13'h0, 8'd9, sr, sb);  run_op(5'd3, sr, sb, 8'd9, 8'd72, 13'h0, "R6");
    aim(W0 + 64'h12, 1'b0, 13'h0, 8'd9, sr, sb);  run_op(5'd2, sr, sb, 8'd9, 8'd73, 13'h0, "R6");
    // R7: byte and halfword stores of low bits
    aim(W0 + 64'h31, 1'b0, 13'h0, 8'd10, sr, sb); run_op(5'd8, sr, sb, 8'd10, 8'd74, 13'h0, "R7");
    aim(W0 + 64'h35, 1'b1, 13'h0, 8'd10, sr, sb); run_op(5'd9, sr, sb, 8'd10, 8'd75, 13'h0, "R7");
    // R8: low then high half into the same register
    mem[10'h051] = 8'h3A; mem[10'h052] = 8'hF1;
    aim(W0 + 64'h51, 1'b0, 13'h0, 8'd11, sr, sb); run_op(5'd16, sr, sb, 8'd11, 8'd80, 13'h0, "R8");
    aim(W0 + 64'h52, 1'b0, 13'h0, 8'd11, sr, sb); run_op(5'd21, sr, sb, 8'd11, 8'd80, 13'h0, "R8");
    aim(W0 + 64'h60, 1'b0, 13'h0, 8'd11, sr, sb); run_op(5'd22, sr, sb, 8'd11, 8'd81, 13'h0, "R8");
    aim(W0 + 64'h52, 1'b0, 13'h0, 8'd11, sr, sb); run_op(5'd17, sr, sb, 8'd11, 8'd81, 13'h0, "R8");
    aim(W0 + 64'h64, 1'b1, 13'h0, 8'd11, sr, sb); run_op(5'd18, sr, sb, 8'd11, 8'd82, 13'h0, "R8");
    // R9: upper-half stores
    aim(W0 + 64'h71, 1'b0, 13'h0, 8'd12, sr, sb); run_op(5'd24, sr, sb, 8'd12, 8'd83, 13'h0, "R9");
    aim(W0 + 64'h75, 1'b0, 13'h0, 8'd12, sr, sb); run_op(5'd25, sr, sb, 8'd12, 8'd84, 13'h0, "R9");
    // R10: beats leaving a window
    aim(W0 + 64'hF8, 1'b0, 13'h0, 8'd13, sr, sb); run_op(5'd6, sr, sb, 8'd13, 8'd90, 13'h0, "R10");
    aim(W0 + 64'hFE, 1'b0, 13'h0, 8'd13, sr, sb); run_op(5'd4, sr, sb, 8'd13, 8'd94, 13'h0, "R10");
    aim(64'h2000, 1'b0, 13'h0, 8'd13, sr, sb);    run_op(5'd12, sr, sb, 8'd13, 8'd95, 13'h0, "R10");
    aim(W1 + 64'hFF, 1'b1, 13'h0, 8'd13, sr, sb); run_op(5'd2, sr, sb, 8'd13, 8'd96, 13'h0, "R10");
    aim(W0 + 64'hFF, 1'b0, 13'h0, 8'd13, sr, sb); run_op(5'd25, sr, sb, 8'd13, 8'd97, 13'h0, "R10");
    // R11: illegal opcodes
    aim(W0 + 64'h10, 1'b0, 13'h0, 8'd14, sr, sb); run_op(5'd10, sr, sb, 8'd14, 8'd98, 13'h0, "R11");
    aim(W0 + 64'h10, 1'b0, 13'h0, 8'd14, sr, sb); run_op(5'd31, sr, sb, 8'd14, 8'd98, 13'h0, "R11");

    for (int n = 0; n < 400; n++) begin
      logic [4:0] c;
      logic [7:0] ar, d;
      logic [12:0] off;
      logic [63:0] tgt;
      c = ($urandom % 20 == 0) ? bad_codes[$urandom % 8] : legal_codes[$urandom % 22];
      ar = 8'($urandom); d = 8'($urandom); off = 13'($urandom);
      tgt = (($urandom % 2) ? W1 : W0) + 64'($urandom % 32'h110) - 64'd8;
      aim(tgt, 1'($urandom), off, ar, sr, sb);
      run_op(c, sr, sb, ar, d, off, tag_of(c));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule